// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a processor core and decides which interrupt, if any, the core takes at the next instruction boundary. It has one non-maskable request line and a parameterized number of maskable lines (three by default). When the core raises its boundary signal and a request is eligible, the block raises a take strobe and a push request in the same cycle, and drives the fixed vector address the core must jump to after it has pushed its program counter. The push, the jump and the stack are handled by the core.

The non-maskable line is edge-triggered. One rising edge is latched as pending and is serviced exactly once, whatever the enable and mask state. Each maskable line is level-sensitive. It is taken only when a global enable flag is set and its own mask bit is clear. Enable and disable commands control the global flag. A mask-write command loads all mask bits together. Accepting a maskable interrupt clears the global flag in hardware, so software must enable it again. A status byte gives the masks, the enable flag and the pending requests.

Top module: `vpic_top`

## Requirements
- R1: Reset clears the global enable, sets every mask bit to 1 and clears the non-maskable pending latch. With all request inputs low after reset, `take` is 0 and `status` reads 0x07.
- R2: A pending non-maskable request is taken at a boundary cycle with `vector` = 0x0024, even when the global enable is 0 and all masks are 1. Taking it does not change the global enable.
- R3: A rising edge on `irq_nmi`, sampled at a clock edge, sets the pending latch. Taking the request clears the latch, so one pulse gives exactly one take. Holding the line high gives no further take. A line already high when reset is released counts as no edge.
- R4: Maskable line 0 vectors to 0x002C, line 1 to 0x0034 and line 2 to 0x003C. A line is eligible only while its input is high, the global enable is 1 and its mask bit is 0.
- R5: `take`, `push_pc` and `vector` respond in the same cycle to `boundary` and the current state. Without `boundary`, or with no eligible request, `take` and `push_pc` are 0 and `vector` is 0x0000.
- R6: When several requests are eligible at once, the non-maskable request wins, then line 2, then line 1, then line 0.
- R7: A `cmd_en` pulse sets the global enable at the next clock edge and a `cmd_dis` pulse clears it. If both are high in the same cycle, the enable ends up cleared.
- R8: A `cmd_mask_wr` pulse loads `mask_wdata` into the masks, with bit i = 1 blocking line i. The new masks apply from the next cycle, so a take in the write cycle uses the old masks.
- R9: Taking a maskable interrupt clears the global enable at that clock edge, even when `cmd_en` is high in the same cycle.
- R10: `status` bits [2:0] are the masks, bit [3] is the global enable, bits [6:4] are the current maskable input levels and bit [7] is the non-maskable pending latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_nmi | input | 1 | Non-maskable request, rising-edge detected |
| irq_m | input | 3 | Maskable requests, level-sensitive; bit i is line i |
| boundary | input | 1 | Core is at an instruction boundary this cycle |
| cmd_en | input | 1 | Set the global enable |
| cmd_dis | input | 1 | Clear the global enable |
| cmd_mask_wr | input | 1 | Load the mask bits from mask_wdata |
| mask_wdata | input | 3 | New mask value; 1 blocks a line |
| take | output | 1 | An interrupt is accepted this cycle |
| push_pc | output | 1 | Core must push its PC before branching |
| vector | output | 16 | Branch target of the accepted interrupt |
| status | output | 8 | Masks, enable and pending bits |

## Verification
The bench uses the default parameters: three maskable lines, a vector base of 0x002C with a step of 8, and 0x0024 for the non-maskable request. These values make every vector address and every status bit visible at the ports as a fixed constant. With three lines, the full priority chain can be exercised, including a line that sits between a masked line and an unmasked one. The cases that depend on timing get their own directed scenarios: a mask write in the same cycle as a take, an enable arriving together with an accepted request, and a non-maskable line held high through reset.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int VEC_W = 16;
  typedef logic [VEC_W-1:0] vec_t;

  // Vector address of maskable line idx: base plus a fixed stride per line.
  function automatic vec_t line_vector(input vec_t base, input vec_t step, input int idx);
    return base + vec_t'(idx) * step;
  endfunction

  // Index of the highest set bit of an eligibility vector, or -1 when none.
  function automatic int highest_set(input logic [31:0] bits, input int width);
    int found;
    found = -1;
    for (int i = 0; i < width; i++) begin
      if (bits[i]) found = i;
    end
    return found;
  endfunction
endpackage

// File: rtl/vpic_nmi_edge.sv
module vpic_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_nmi,
  input  logic take_nmi,
  output logic nmi_pend
);
  logic nmi_q;
  logic nmi_rise;

  assign nmi_rise = irq_nmi & ~nmi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q    <= 1'b1;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= irq_nmi;
      nmi_pend <= nmi_rise | (nmi_pend & ~take_nmi);
    end
  end

  // R3
  nmi_clear_only_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmi_pend) |-> $past(take_nmi));

  // R3
  nmi_take_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |-> nmi_pend);
endmodule

// File: rtl/vpic_enable_regs.sv
module vpic_enable_regs #(
  parameter int N_LINES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_en,
  input  logic               cmd_dis,
  input  logic               cmd_mask_wr,
  input  logic [N_LINES-1:0] mask_wdata,
  input  logic               take_mask,
  output logic               gie,
  output logic [N_LINES-1:0] mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie  <= 1'b0;
      mask <= '1;
    end else begin
      if (take_mask || cmd_dis) gie <= 1'b0;
      else if (cmd_en)          gie <= 1'b1;
      if (cmd_mask_wr) mask <= mask_wdata;
    end
  end

  // R9
  gie_auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_mask |=> !gie);

  // R7
  gie_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && !cmd_dis && !take_mask) |=> gie);

  // R7
  gie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_dis |=> !gie);

  // R8
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_mask_wr |=> (mask == $past(mask_wdata)));
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter
  import vpic_pkg::*;
#(
  parameter int   N_LINES  = 3,
  parameter vec_t NMI_VEC  = 16'h0024,
  parameter vec_t MSK_BASE = 16'h002C,
  parameter vec_t MSK_STEP = 16'h0008
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boundary,
  input  logic               nmi_pend,
  input  logic [N_LINES-1:0] req_lvl,
  input  logic [N_LINES-1:0] mask,
  input  logic               gie,
  output logic               take,
  output logic               take_nmi,
  output logic               take_mask,
  output logic [N_LINES-1:0] grant,
  output vec_t               vector
);
  logic [N_LINES-1:0] elig;
  logic [31:0]        elig_w;
  int                 win_idx;

  for (genvar g = 0; g < N_LINES; g++) begin : g_elig
    assign elig[g] = req_lvl[g] & ~mask[g] & gie;
  end

  assign elig_w = 32'(elig);

  always_comb begin
    win_idx = highest_set(elig_w, N_LINES);
    grant   = '0;
    if (boundary && !nmi_pend && win_idx >= 0) grant[win_idx] = 1'b1;
  end

  assign take_nmi  = boundary & nmi_pend;
  assign take_mask = |grant;
  assign take      = take_nmi | take_mask;

  always_comb begin
    if (take_nmi)       vector = NMI_VEC;
    else if (take_mask) vector = line_vector(MSK_BASE, MSK_STEP, win_idx);
    else                vector = '0;
  end

  // R6
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R4
  grant_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_mask |-> (gie && ((grant & mask) == '0) && ((grant & req_lvl) == grant)));
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int   N_LINES  = 3,
  parameter vec_t NMI_VEC  = 16'h0024,
  parameter vec_t MSK_BASE = 16'h002C,
  parameter vec_t MSK_STEP = 16'h0008,
  localparam int  STAT_W   = 2 * N_LINES + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_nmi,
  input  logic [N_LINES-1:0] irq_m,
  input  logic               boundary,
  input  logic               cmd_en,
  input  logic               cmd_dis,
  input  logic               cmd_mask_wr,
  input  logic [N_LINES-1:0] mask_wdata,
  output logic               take,
  output logic               push_pc,
  output logic [VEC_W-1:0]   vector,
  output logic [STAT_W-1:0]  status
);
  logic               nmi_pend;
  logic               take_nmi;
  logic               take_mask;
  logic               gie;
  logic [N_LINES-1:0] mask;
  logic [N_LINES-1:0] grant;

  vpic_nmi_edge u_nmi (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_nmi  (irq_nmi),
    .take_nmi (take_nmi),
    .nmi_pend (nmi_pend)
  );

  vpic_enable_regs #(.N_LINES(N_LINES)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_en      (cmd_en),
    .cmd_dis     (cmd_dis),
    .cmd_mask_wr (cmd_mask_wr),
    .mask_wdata  (mask_wdata),
    .take_mask   (take_mask),
    .gie         (gie),
    .mask        (mask)
  );

  vpic_arbiter #(
    .N_LINES  (N_LINES),
    .NMI_VEC  (NMI_VEC),
    .MSK_BASE (MSK_BASE),
    .MSK_STEP (MSK_STEP)
  ) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .boundary  (boundary),
    .nmi_pend  (nmi_pend),
    .req_lvl   (irq_m),
    .mask      (mask),
    .gie       (gie),
    .take      (take),
    .take_nmi  (take_nmi),
    .take_mask (take_mask),
    .grant     (grant),
    .vector    (vector)
  );

  assign push_pc = take;
  assign status  = {nmi_pend, irq_m, gie, mask};

  // R5
  take_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> boundary);

  // R2
  nmi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && nmi_pend) |-> (take && vector == NMI_VEC && grant == '0));

  // R2
  nmi_keeps_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_nmi && !cmd_en && !cmd_dis) |=> (gie == $past(gie)));
endmodule

// File: tb/vpic_top_bench.sv
module vpic_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_nmi = 1'b0;
  logic [2:0]  irq_m = '0;
  logic        boundary = 1'b0;
  logic        cmd_en = 1'b0;
  logic        cmd_dis = 1'b0;
  logic        cmd_mask_wr = 1'b0;
  logic [2:0]  mask_wdata = '0;
  logic        take;
  logic        push_pc;
  logic [15:0] vector;
  logic [7:0]  status;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vpic_top u_vpic_top (
    .clk(clk), .rst_n(rst_n), .irq_nmi(irq_nmi), .irq_m(irq_m),
    .boundary(boundary), .cmd_en(cmd_en), .cmd_dis(cmd_dis),
    .cmd_mask_wr(cmd_mask_wr), .mask_wdata(mask_wdata),
    .take(take), .push_pc(push_pc), .vector(vector), .status(status)
  );

  function automatic logic [15:0] exp_vec(input int line);
    case (line)
      0: return 16'h002C;
      1: return 16'h0034;
      default: return 16'h003C;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive after the falling edge; outputs are sampled 1 ns later.
  task automatic step();
    @(negedge clk);
    cmd_en = 1'b0; cmd_dis = 1'b0; cmd_mask_wr = 1'b0; boundary = 1'b0;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    boundary = 1'b0; cmd_en = 1'b0; cmd_dis = 1'b0; cmd_mask_wr = 1'b0;
  endtask

  task automatic enable_all();
    step(); cmd_en = 1'b1; cmd_mask_wr = 1'b1; mask_wdata = 3'b000;
    step();
  endtask

  task automatic t_reset();
    irq_m = '0; irq_nmi = 1'b0;
    do_reset();
    settle();
    chk("R1", "status after reset", status, 8'h07);
    chk("R1", "take after reset", take, 1'b0);
  endtask

  task automatic t_nmi();
    step(); irq_nmi = 1'b1;
    step(); irq_nmi = 1'b0; settle();
    chk("R3", "pending after pulse", status[7], 1'b1);
    chk("R5", "no take without boundary", take, 1'b0);
    chk("R5", "vector idle", vector, 16'h0000);
    step(); boundary = 1'b1; settle();
    chk("R2", "nmi take while gie=0 masks=1", take, 1'b1);
    chk("R2", "nmi push", push_pc, 1'b1);
    chk("R2", "nmi vector", vector, 16'h0024);
    step(); boundary = 1'b1; settle();
    chk("R3", "one pulse one take", take, 1'b0);
    chk("R3", "pending cleared", status[7], 1'b0);
    // held high: single edge only
    step(); irq_nmi = 1'b1;
    step(); boundary = 1'b1; settle();
    chk("R3", "held line first take", take, 1'b1);
    step(); boundary = 1'b1; settle();
    chk("R3", "held line no second take", take, 1'b0);
    // high through reset
    do_reset();
    step(); boundary = 1'b1; settle();
    chk("R3", "high through reset no take", take, 1'b0);
    step(); irq_nmi = 1'b0;
    step();
  endtask

  task automatic t_lines();
    for (int i = 0; i < 3; i++) begin
      enable_all();
      irq_m = 3'(1 << i);
      step(); boundary = 1'b1; settle();
      chk("R4", $sformatf("line %0d take", i), take, 1'b1);
      chk("R4", $sformatf("line %0d vector", i), vector, exp_vec(i));
      step(); boundary = 1'b1; settle();
      chk("R9", $sformatf("line %0d gie cleared", i), status[3], 1'b0);
      chk("R4", $sformatf("line %0d blocked by gie", i), take, 1'b0);
      irq_m = '0;
    end
  endtask

  task automatic t_priority();
    enable_all();
    irq_m = 3'b111;
    step(); irq_nmi = 1'b1;
    step(); irq_nmi = 1'b0; boundary = 1'b1; settle();
    chk("R6", "nmi over all lines", vector, 16'h0024);
    step(); boundary = 1'b1; settle();
    chk("R2", "gie kept after nmi", status[3], 1'b1);
    chk("R6", "line2 over 1 and 0", vector, 16'h003C);
    enable_all(); irq_m = 3'b011;
    boundary = 1'b1; settle();
    chk("R6", "line1 over 0", vector, 16'h0034);
    enable_all(); irq_m = 3'b101;
    boundary = 1'b1; settle();
    chk("R6", "line2 over 0", vector, 16'h003C);
    irq_m = '0;
  endtask

  task automatic t_commands();
    enable_all();
    settle();
    chk("R7", "enable sets gie", status[3], 1'b1);
    step(); cmd_en = 1'b1; cmd_dis = 1'b1;
    step(); settle();
    chk("R7", "disable wins", status[3], 1'b0);
    // mask 101: only line 1 passes
    step(); cmd_en = 1'b1; cmd_mask_wr = 1'b1; mask_wdata = 3'b101;
    step(); irq_m = 3'b111; boundary = 1'b1; settle();
    chk("R8", "masked lines skipped", vector, 16'h0034);
    // write timing: masks 111, write 000 in a boundary cycle
    step(); cmd_en = 1'b1; cmd_mask_wr = 1'b1; mask_wdata = 3'b111;
    step(); cmd_mask_wr = 1'b1; mask_wdata = 3'b000; boundary = 1'b1; settle();
    chk("R8", "old mask in write cycle", take, 1'b0);
    step(); boundary = 1'b1; settle();
    chk("R8", "new mask next cycle", vector, 16'h003C);
    // take with concurrent enable
    step(); cmd_en = 1'b1;
    step(); boundary = 1'b1; cmd_en = 1'b1; settle();
    chk("R9", "take with enable", take, 1'b1);
    step(); settle();
    chk("R9", "take beats enable", status[3], 1'b0);
    irq_m = '0;
  endtask

  task automatic t_status();
    step(); cmd_en = 1'b1; cmd_mask_wr = 1'b1; mask_wdata = 3'b010;
    step(); irq_m = 3'b110; irq_nmi = 1'b1;
    step(); settle();
    chk("R10", "status layout", status, {1'b1, 3'b110, 1'b1, 3'b010});
    irq_nmi = 1'b0; irq_m = '0;
    step();
  endtask

  initial begin
    t_reset();
    t_nmi();
    t_lines();
    t_priority();
    t_commands();
    t_status();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule